// File: doc/BRIEF.md
# Cancellable Pipeline Control Tracker

This block is the control half of a multi-stage execution unit. It runs beside a data pipeline that only computes, and for every pipeline slot it records which reservation station owns the work and whether the slot still holds a live instruction. Issue requests arrive tagged with a station index. Station numbers are released as soon as their work is abandoned, so the data path never has to see cancellation.

A cancel arrives as a mask with one bit per station, which is a unary form of the station index. In the same cycle, every in-flight slot owned by a flagged station becomes an empty bubble. The flagged station is also marked free, so it can take a new issue on the next cycle without waiting for the pipeline to drain. Bubbles keep moving down the stages in order and are never refilled mid-pipeline. At the far end the block presents the station index, the data and a valid strobe, so the consumer can ignore results from cancelled slots.

Two parameters shape the pipeline. `NUM_STAGES` sets how many compute steps there are. `REG_MASK` says which steps end in a register, so that several steps can share one clock cycle. A stand-in data path passes the data through with matching delay. Each slot also carries a generation bit. A leftover result can therefore never be credited to a later issue on the same station.

Top module: `cancel_pipe_tracker`

## Requirements
- R1: Synchronous reset clears every station busy flag and every slot valid bit. After reset, `issueReady` is 1 for every station and `resValid` is 0.
- R2: `issueReady` equals the inverse of the busy flag of the station on `issueStation`. An issue presented while that station is busy is refused and produces no result.
- R3: An accepted issue that is not cancelled appears on `resValid`/`resStation`/`resData` exactly LAT cycles later, with its own station index and data. LAT is the number of set bits in `REG_MASK` (3 by default).
- R4: When bit s of `cancelMask` is 1 in a cycle, no in-flight result owned by station s is ever presented, including one due at the output in that same cycle.
- R5: A station whose `cancelMask` bit is 1 in a cycle has `issueReady` = 1 in the following cycle.
- R6: An issue accepted in the same cycle as a cancel for its own station produces no result, and the station is free in the next cycle.
- R7: Cancelled slots become bubbles. Results of other stations that are in flight keep their order and their cycle of arrival.
- R8: The cycle after a result is presented for station s, station s shows `issueReady` = 1.
- R9: If a station is cancelled and then re-issued while its old slot would still be in flight, only the new issue's result is reported, at the new issue's timing and with the new data.
- R10: A `cancelMask` bit for a station that is not busy changes neither the results nor the readiness of any other station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | Issue request present |
| issueStation | input | IDX_W | Station index of the issue request |
| issueData | input | DATA_W | Operand sent down the data pipeline |
| issueReady | output | 1 | Requested station is free, so the issue is accepted |
| cancelMask | input | NUM_ST | One bit per station, 1 abandons that station's work |
| resValid | output | 1 | A live result is at the pipeline end |
| resStation | output | IDX_W | Station owning the result |
| resData | output | DATA_W | Result data |

## Verification
The hardest case to reach is a station that is cancelled while its slot is mid-pipeline and then re-issued at once. Two slots for the same station are then in flight, one dead and one live. The stimulus issues to a station, cancels it one cycle later, re-issues it with different data on the next cycle, and checks that only the second operand arrives, at its own due cycle. A cancel that lands in the same cycle as the issue, and a long stretch of pseudo-random issues and cancels, further stress these collisions. A behavioural model that tracks each issue by its due cycle predicts the expected outputs.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  // strobe from control to datapath for one stage
  typedef struct packed {
    logic load;
  } stageStrobe_t;

  function automatic int countRegs(input int n, input logic [63:0] mask);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) c += int'(mask[i]);
    return c;
  endfunction

endpackage

// File: rtl/cpt_station_table.sv
module cpt_station_table #(
  parameter int NUM_ST = 8,
  parameter int IDX_W  = $clog2(NUM_ST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueFire,
  input  logic [IDX_W-1:0]  issueStation,
  input  logic [NUM_ST-1:0] cancelMask,
  input  logic              retireValid,
  input  logic [IDX_W-1:0]  retireStation,
  output logic [NUM_ST-1:0] busy,
  output logic [NUM_ST-1:0] gen
);

  for (genvar s = 0; s < NUM_ST; s++) begin : st
    logic setHit;
    logic clrHit;
    assign setHit = issueFire && (issueStation == IDX_W'(s));
    assign clrHit = retireValid && (retireStation == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        busy[s] <= 1'b0;
        gen[s]  <= 1'b0;
      end else begin
        busy[s] <= (busy[s] | setHit) & ~cancelMask[s] & ~clrHit;
        gen[s]  <= gen[s] ^ cancelMask[s];
      end
    end
  end

endmodule

// File: rtl/cpt_slot_chain.sv
module cpt_slot_chain
  import cpt_pkg::*;
#(
  parameter int                    NUM_ST     = 8,
  parameter int                    IDX_W      = $clog2(NUM_ST),
  parameter int                    NUM_STAGES = 6,
  parameter logic [NUM_STAGES-1:0] REG_MASK   = '1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           inValid,
  input  logic [IDX_W-1:0]               inStation,
  input  logic                           inGen,
  input  logic [NUM_ST-1:0]              cancelMask,
  input  logic [NUM_ST-1:0]              gen,
  output logic                           outValid,
  output logic [IDX_W-1:0]               outStation,
  output stageStrobe_t [NUM_STAGES-1:0]  strobe
);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : stg
    logic             vIn, gIn, vLive;
    logic [IDX_W-1:0] sIn;
    logic             vQ, gQ;
    logic [IDX_W-1:0] sQ;

    if (i == 0) begin : head
      assign vIn = inValid;
      assign sIn = inStation;
      assign gIn = inGen;
    end else begin : link
      assign vIn = stg[i-1].vQ;
      assign sIn = stg[i-1].sQ;
      assign gIn = stg[i-1].gQ;
    end

    // a slot owned by a cancelled station is emptied where it sits
    assign vLive = vIn & ~cancelMask[sIn];

    if (REG_MASK[i]) begin : flop
      always_ff @(posedge clk) begin
        if (rst) begin
          vQ <= 1'b0;
          sQ <= '0;
          gQ <= 1'b0;
        end else begin
          vQ <= vLive;
          sQ <= sIn;
          gQ <= gIn;
        end
      end
      assign strobe[i].load = vLive;
    end else begin : thru
      assign vQ = vLive;
      assign sQ = sIn;
      assign gQ = gIn;
      assign strobe[i].load = 1'b0;
    end
  end

  logic             lastV, lastG;
  logic [IDX_W-1:0] lastS;
  assign lastV = stg[NUM_STAGES-1].vQ;
  assign lastS = stg[NUM_STAGES-1].sQ;
  assign lastG = stg[NUM_STAGES-1].gQ;

  assign outValid   = lastV & ~cancelMask[lastS] & (lastG == gen[lastS]);
  assign outStation = lastS;

endmodule

// File: rtl/cpt_data_chain.sv
module cpt_data_chain
  import cpt_pkg::*;
#(
  parameter int                    DATA_W     = 16,
  parameter int                    NUM_STAGES = 6,
  parameter logic [NUM_STAGES-1:0] REG_MASK   = '1
) (
  input  logic                          clk,
  input  logic [DATA_W-1:0]             inData,
  input  stageStrobe_t [NUM_STAGES-1:0] strobe,
  output logic [DATA_W-1:0]             outData
);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : stg
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] q;

    if (i == 0) begin : head
      assign d = inData;
    end else begin : link
      assign d = stg[i-1].q;
    end

    // stand-in for one compute step: delay-matched pass-through
    assign step = d;

    if (REG_MASK[i]) begin : flop
      always_ff @(posedge clk) begin
        if (strobe[i].load) q <= step;
      end
    end else begin : thru
      logic unusedLoad;
      assign unusedLoad = strobe[i].load;
      assign q = step;
    end
  end

  assign outData = stg[NUM_STAGES-1].q;

endmodule

// File: rtl/cancel_pipe_tracker.sv
module cancel_pipe_tracker
  import cpt_pkg::*;
#(
  parameter int                    NUM_ST     = 8,
  parameter int                    IDX_W      = $clog2(NUM_ST),
  parameter int                    DATA_W     = 16,
  parameter int                    NUM_STAGES = 6,
  parameter logic [NUM_STAGES-1:0] REG_MASK   = 6'b101010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueStation,
  input  logic [DATA_W-1:0] issueData,
  output logic              issueReady,
  input  logic [NUM_ST-1:0] cancelMask,
  output logic              resValid,
  output logic [IDX_W-1:0]  resStation,
  output logic [DATA_W-1:0] resData
);

  localparam int LAT = countRegs(NUM_STAGES, 64'(REG_MASK));

  logic [NUM_ST-1:0]             stationBusy;
  logic [NUM_ST-1:0]             stationGen;
  logic                          issueFire;
  stageStrobe_t [NUM_STAGES-1:0] strobe;

  assign issueReady = ~stationBusy[issueStation];
  assign issueFire  = issueValid & issueReady;

  cpt_station_table #(.NUM_ST(NUM_ST), .IDX_W(IDX_W)) tableI (
    .clk(clk), .rst(rst),
    .issueFire(issueFire), .issueStation(issueStation),
    .cancelMask(cancelMask),
    .retireValid(resValid), .retireStation(resStation),
    .busy(stationBusy), .gen(stationGen)
  );

  cpt_slot_chain #(
    .NUM_ST(NUM_ST), .IDX_W(IDX_W),
    .NUM_STAGES(NUM_STAGES), .REG_MASK(REG_MASK)
  ) ctlI (
    .clk(clk), .rst(rst),
    .inValid(issueFire), .inStation(issueStation),
    .inGen(stationGen[issueStation]),
    .cancelMask(cancelMask), .gen(stationGen),
    .outValid(resValid), .outStation(resStation),
    .strobe(strobe)
  );

  cpt_data_chain #(
    .DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES), .REG_MASK(REG_MASK)
  ) dpI (
    .clk(clk), .inData(issueData), .strobe(strobe), .outData(resData)
  );

  logic unusedLat;
  assign unusedLat = (LAT >= 0);

endmodule

// File: rtl/cancel_pipe_tracker_chk.sv
module cancel_pipe_tracker_chk #(
  parameter int NUM_ST = 8,
  parameter int IDX_W  = $clog2(NUM_ST)
) (
  input logic              clk,
  input logic              rst,
  input logic              issueValid,
  input logic              issueReady,
  input logic [IDX_W-1:0]  issueStation,
  input logic [NUM_ST-1:0] cancelMask,
  input logic              resValid,
  input logic [IDX_W-1:0]  resStation,
  input logic [NUM_ST-1:0] stationBusy
);

  AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueReady && !cancelMask[issueStation] &&
     !(resValid && resStation == issueStation))
    |=> stationBusy[$past(issueStation)]); // R2

  AST_CANCEL_FREES: assert property (@(posedge clk) disable iff (rst)
    (|cancelMask) |=> ((stationBusy & $past(cancelMask)) == '0)); // R5

  AST_NO_CANCELLED_RESULT: assert property (@(posedge clk) disable iff (rst)
    resValid |-> !cancelMask[resStation]); // R4

  AST_RESULT_OWNED: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (stationBusy[resStation] ||
                  (issueValid && issueReady && issueStation == resStation))); // R9

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !stationBusy[$past(resStation)]); // R8

endmodule

bind cancel_pipe_tracker cancel_pipe_tracker_chk #(.NUM_ST(NUM_ST), .IDX_W(IDX_W)) chkI (
  .clk(clk), .rst(rst), .issueValid(issueValid), .issueReady(issueReady),
  .issueStation(issueStation), .cancelMask(cancelMask),
  .resValid(resValid), .resStation(resStation), .stationBusy(stationBusy)
);

// File: tb/cancel_pipe_tracker_tb_top.sv
module cancel_pipe_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ST     = 8;
  localparam int IDX_W      = 3;
  localparam int DATA_W     = 16;
  localparam int NUM_STAGES = 6;
  localparam logic [NUM_STAGES-1:0] REG_MASK = 6'b101010;
  localparam int LAT = 3; // set bits in REG_MASK

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              issueValid = 1'b0;
  logic [IDX_W-1:0]  issueStation = '0;
  logic [DATA_W-1:0] issueData = '0;
  logic              issueReady;
  logic [NUM_ST-1:0] cancelMask = '0;
  logic              resValid;
  logic [IDX_W-1:0]  resStation;
  logic [DATA_W-1:0] resData;

  always #(CLK_PERIOD/2) clk = ~clk;

  cancel_pipe_tracker #(
    .NUM_ST(NUM_ST), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .NUM_STAGES(NUM_STAGES), .REG_MASK(REG_MASK)
  ) dut_i (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueStation(issueStation),
    .issueData(issueData), .issueReady(issueReady), .cancelMask(cancelMask),
    .resValid(resValid), .resStation(resStation), .resData(resData)
  );

  typedef struct {
    int st;
    int data;
    int due;
    bit alive;
  } entry_t;

  entry_t  inflight[$];
  bit      mBusy[NUM_ST];
  int      cyc = 0;
  int      checks = 0;
  int      errors = 0;
  string   curReq = "R1";
  bit      finished = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", curReq, what, cyc, act, exp);
    end
  endtask

  // one clock cycle: drive, compare against model, advance model
  task automatic step(input bit iv, input int st, input int d, input logic [NUM_ST-1:0] m);
    bit expValid;
    int expSt, expData;
    bit accept;
    issueValid   = iv;
    issueStation = IDX_W'(st);
    issueData    = DATA_W'(d);
    cancelMask   = m;
    #1;
    expValid = 1'b0; expSt = 0; expData = 0;
    foreach (inflight[k]) begin
      if (inflight[k].alive && inflight[k].due == cyc && !m[inflight[k].st]) begin
        expValid = 1'b1; expSt = inflight[k].st; expData = inflight[k].data;
      end
    end
    chk(issueReady == !mBusy[st], "issueReady", int'(issueReady), int'(!mBusy[st]));
    chk(resValid == expValid, "resValid", int'(resValid), int'(expValid));
    if (expValid && resValid) begin
      chk(int'(resStation) == expSt, "resStation", int'(resStation), expSt);
      chk(int'(resData) == expData, "resData", int'(resData), expData);
    end
    // model update at the coming edge
    accept = iv && !mBusy[st];
    if (expValid) mBusy[expSt] = 1'b0;
    foreach (inflight[k]) if (m[inflight[k].st]) inflight[k].alive = 1'b0;
    for (int s = 0; s < NUM_ST; s++) if (m[s]) mBusy[s] = 1'b0;
    if (accept) begin
      entry_t e;
      e.st = st; e.data = d & 16'hFFFF; e.due = cyc + LAT; e.alive = !m[st];
      inflight.push_back(e);
      mBusy[st] = !m[st];
    end
    while (inflight.size() > 0 && inflight[0].due <= cyc) void'(inflight.pop_front());
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < NUM_ST; s++) mBusy[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: all stations free, nothing valid after reset
    curReq = "R1";
    for (int s = 0; s < NUM_ST; s++) step(1'b0, s, 0, '0);
    // R3: basic latency and data
    curReq = "R3";
    step(1'b1, 1, 16'h1111, '0);
    idle(LAT + 1);
    // R2: second issue to a busy station is refused
    curReq = "R2";
    step(1'b1, 2, 16'h2222, '0);
    step(1'b1, 2, 16'hBAD2, '0);
    idle(LAT + 1);
    // R4 and R7: cancel a middle slot, neighbours keep timing
    curReq = "R7";
    step(1'b1, 3, 16'h3333, '0);
    step(1'b1, 4, 16'h4444, '0);
    curReq = "R4";
    step(1'b1, 5, 16'h5555, 8'b0001_0000);
    curReq = "R7";
    idle(LAT + 1);
    // R4: cancel in the cycle the result is due
    curReq = "R4";
    step(1'b1, 3, 16'h3A3A, '0);
    idle(LAT - 1);
    step(1'b0, 0, 0, 8'b0000_1000);
    idle(2);
    // R5: cancel then immediate re-issue check of readiness
    curReq = "R5";
    step(1'b1, 6, 16'h6666, '0);
    step(1'b0, 6, 0, 8'b0100_0000);
    step(1'b0, 6, 0, '0);
    idle(LAT + 1);
    // R6: issue and cancel of the same station in one cycle
    curReq = "R6";
    step(1'b1, 7, 16'h7777, 8'b1000_0000);
    step(1'b0, 7, 0, '0);
    idle(LAT + 1);
    // R8: station free the cycle after its result
    curReq = "R8";
    step(1'b1, 0, 16'h0808, '0);
    idle(LAT);
    step(1'b1, 0, 16'h0809, '0);
    idle(LAT + 1);
    // R9: cancel then re-issue while old slot still in flight
    curReq = "R9";
    step(1'b1, 2, 16'hAAAA, '0);
    step(1'b0, 2, 0, 8'b0000_0100);
    step(1'b1, 2, 16'hBBBB, '0);
    idle(LAT + 1);
    // R10: cancel bits of idle stations do not disturb a live slot
    curReq = "R10";
    step(1'b1, 1, 16'h1010, '0);
    step(1'b0, 1, 0, 8'b1111_1101);
    step(1'b0, 1, 0, 8'b0111_0001);
    idle(LAT);
    // R7: pseudo-random mix of issues and cancels
    curReq = "R7";
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [NUM_ST-1:0] m;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = (lfsr[3:0] == 4'd0) ? NUM_ST'(1) << lfsr[6:4] : '0;
      step(lfsr[7] | lfsr[8], int'(lfsr[11:9]), int'(lfsr ^ 16'h5A5A), m);
    end
    idle(LAT + 2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule